// File: doc/BRIEF.md
# Car Park Occupancy Counter

This block keeps a running count of the cars inside a car park. One presence sensor sits at the entry lane and another at the exit lane. Each sensor holds its output high for as long as a car stands in front of it, so the high time can be any length. The block turns each high period into exactly one event. It then moves a saturating occupancy count up or down and reports whether the park is full or empty.

An event that cannot be honoured produces a one-cycle error pulse and leaves the count unchanged. There are two such events: a departure from an empty park and an arrival at a full one. An arrival and a departure seen in the same cycle cancel out and are always accepted.

Each accepted arrival or departure also produces a one-cycle strobe. A separate time-of-day block can use these strobes to stamp the moment of entry or exit.

Both sensor inputs may be asynchronous to the system clock. Each one passes through a synchroniser before its rising edge is detected. A synchronous active-low reset and a synchronous clear both return the count to zero.

Top module: `parking_occupancy`

## Requirements
- R1: An accepted arrival raises `car_count` by one and an accepted departure lowers it by one. `car_count` is an unsigned binary value from 0 to MAX_CARS, where MAX_CARS defaults to 1024 and the port is 11 bits wide.
- R2: A sensor high period of any length, from one clock cycle upwards, counts as exactly one event. Only a low-to-high change of the synchronised level is used.
- R3: A lone departure while `car_count` is 0 pulses `err_pulse` and leaves `car_count` at 0. No `exited_stb` is produced.
- R4: A lone arrival while `car_count` equals MAX_CARS pulses `err_pulse` and leaves `car_count` at MAX_CARS. No `entered_stb` is produced.
- R5: An arrival and a departure detected in the same cycle leave `car_count` unchanged. They raise no error, pulse both `entered_stb` and `exited_stb`, and this holds at 0 and at MAX_CARS as well.
- R6: `full` is high exactly when `car_count` equals MAX_CARS. `empty` is high exactly when `car_count` is 0.
- R7: While `rst_n` is low at a clock edge, the design sets `car_count` to 0, `err_pulse` to 0 and both strobes to 0.
- R8: A high `clear` at a clock edge sets `car_count` to 0 and `err_pulse` and both strobes to 0. Sensor events detected in that cycle are dropped.
- R9: `err_pulse`, `entered_stb` and `exited_stb` are each high for a single cycle per event.
- R10: A sensor level first sampled high at clock edge k produces its count change, strobe or error at clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of count and error, active high |
| entry_sense | input | 1 | Entry lane presence sensor, high while a car is present |
| exit_sense | input | 1 | Exit lane presence sensor, high while a car is present |
| car_count | output | 11 | Cars currently inside |
| full | output | 1 | Count equals MAX_CARS |
| empty | output | 1 | Count equals zero |
| err_pulse | output | 1 | One-cycle pulse on a rejected event |
| entered_stb | output | 1 | One-cycle pulse on an accepted arrival |
| exited_stb | output | 1 | One-cycle pulse on an accepted departure |

## Verification
A sensor level driven between edges is caught by the first synchroniser flop on the next edge. The count, the strobes and the error appear on the second edge after that, so results are due three rising edges after the drive. The bench therefore samples at the falling edge that follows the third rising edge, and one cycle later it confirms that the pulses have dropped. `full` and `empty` follow the count with no added delay and are checked in that same sample. A `clear` or reset takes effect on the next edge and is checked at the falling edge just after it.

// File: rtl/occ_pkg.sv
// Package: shared types for the car park occupancy counter.
// Assumes: nothing beyond IEEE 1800-2017.
package occ_pkg;

    // Action the counter takes in one cycle
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_UP     = 2'd1,
        ACT_DOWN   = 2'd2,
        ACT_REJECT = 2'd3
    } occ_act_e;

    // Number of sensor lanes handled by the top level
    localparam int unsigned LANES = 2;

endpackage

// File: rtl/sensor_edge.sv
// Module: sensor_edge
// Brings one asynchronous presence-sensor level into the clock domain
// through SYNC_STAGES flops and emits a single-cycle pulse on each
// low-to-high change of the synchronised level.
// Assumes: a low period of at least SYNC_STAGES cycles between cars.
module sensor_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_i,
    output logic rise_o
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Purpose: shift the raw level through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sense_i};
        end
    end

    // Purpose: remember the last synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    // Purpose: pulse when the synchronised level has just gone high
    always_comb begin
        rise_o = sync_q[LAST] & ~prev_q;
    end

    // R2: an edge pulse never lasts two cycles
    a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/occ_counter.sv
// Module: occ_counter
// Saturating up/down occupancy counter. An arrival and a departure in
// the same cycle cancel out. A lone departure at zero or a lone
// arrival at MAX_CARS is rejected with a one-cycle error pulse.
// Accepted events produce registered one-cycle strobes.
// Assumes: inc_i and dec_i are single-cycle pulses.
module occ_counter
    import occ_pkg::*;
#(
    parameter int unsigned MAX_CARS = 1024,
    parameter int unsigned CNT_W    = $clog2(MAX_CARS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] count_o,
    output logic             err_o,
    output logic             in_stb_o,
    output logic             out_stb_o
);

    localparam logic [CNT_W-1:0] TOP  = CNT_W'(MAX_CARS);
    localparam logic [CNT_W-1:0] ZERO = '0;

    occ_act_e act;
    logic     acc_in;
    logic     acc_out;

    // Purpose: decide this cycle's action from the two events
    always_comb begin
        act     = ACT_HOLD;
        acc_in  = 1'b0;
        acc_out = 1'b0;
        if (inc_i && dec_i) begin
            acc_in  = 1'b1;
            acc_out = 1'b1;
        end else if (inc_i) begin
            if (count_o == TOP) begin
                act = ACT_REJECT;
            end else begin
                act    = ACT_UP;
                acc_in = 1'b1;
            end
        end else if (dec_i) begin
            if (count_o == ZERO) begin
                act = ACT_REJECT;
            end else begin
                act     = ACT_DOWN;
                acc_out = 1'b1;
            end
        end
    end

    // Purpose: update the occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            count_o <= ZERO;
        end else begin
            case (act)
                ACT_UP:   count_o <= count_o + 1'b1;
                ACT_DOWN: count_o <= count_o - 1'b1;
                default:  count_o <= count_o;
            endcase
        end
    end

    // Purpose: register the error pulse and the event strobes
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            err_o     <= 1'b0;
            in_stb_o  <= 1'b0;
            out_stb_o <= 1'b0;
        end else begin
            err_o     <= (act == ACT_REJECT);
            in_stb_o  <= acc_in;
            out_stb_o <= acc_out;
        end
    end

    // R4: count never exceeds the limit
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= TOP);

    // R4: lone arrival when full keeps the count and flags an error
    a_r4_full_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i && !dec_i && count_o == TOP) |=> (count_o == TOP && err_o && !in_stb_o));

    // R3: lone departure when empty keeps zero and flags an error
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && dec_i && !inc_i && count_o == ZERO) |=> (count_o == ZERO && err_o && !out_stb_o));

    // R5: paired events leave the count alone without error
    a_r5_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i && dec_i) |=> ($stable(count_o) && !err_o && in_stb_o && out_stb_o));

    // R1: without a clear, the count moves by at most one per cycle
    a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1
                    || count_o == $past(count_o) - 1'b1));

    // R8: clear empties the park
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == ZERO && !err_o));

    // R9: error never stays up two cycles
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

endmodule

// File: rtl/parking_occupancy.sv
// Module: parking_occupancy (top)
// Car park occupancy counter: synchronises and edge-detects the entry
// and exit sensors, keeps a saturating count and derives full/empty.
// Assumes: sensors stay low at least SYNC_STAGES cycles between cars.
module parking_occupancy
    import occ_pkg::*;
#(
    parameter int unsigned MAX_CARS    = 1024,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = $clog2(MAX_CARS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             entry_sense,
    input  logic             exit_sense,
    output logic [CNT_W-1:0] car_count,
    output logic             full,
    output logic             empty,
    output logic             err_pulse,
    output logic             entered_stb,
    output logic             exited_stb
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_CARS);

    logic [LANES-1:0] sense_raw;
    logic [LANES-1:0] sense_rise;

    assign sense_raw = {exit_sense, entry_sense};

    // One synchroniser and edge detector per lane (0 = entry, 1 = exit)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sensor_edge #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sense_i(sense_raw[g]),
            .rise_o (sense_rise[g])
        );
    end

    occ_counter #(
        .MAX_CARS(MAX_CARS),
        .CNT_W   (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clear),
        .inc_i    (sense_rise[0]),
        .dec_i    (sense_rise[1]),
        .count_o  (car_count),
        .err_o    (err_pulse),
        .in_stb_o (entered_stb),
        .out_stb_o(exited_stb)
    );

    // Purpose: derive the full and empty flags from the count
    always_comb begin
        full  = (car_count == TOP);
        empty = (car_count == '0);
    end

    // R6: the park is never both full and empty
    a_r6_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full, empty}));

    // R9: an accepted arrival strobe lasts one cycle
    a_r9_entry_stb: assert property (@(posedge clk) disable iff (!rst_n)
        entered_stb |=> !entered_stb);

    // R9: an accepted departure strobe lasts one cycle
    a_r9_exit_stb: assert property (@(posedge clk) disable iff (!rst_n)
        exited_stb |=> !exited_stb);

endmodule

// File: tb/parking_occupancy_tb.sv
module parking_occupancy_tb;

    localparam int MAX = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        entry_sense = 1'b0;
    logic        exit_sense = 1'b0;
    logic [10:0] car_count;
    logic        full, empty, err_pulse, entered_stb, exited_stb;

    int n_run  = 0;
    int n_fail = 0;
    int exp_count = 0;

    always #4 clk = ~clk;

    parking_occupancy u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .entry_sense(entry_sense),
        .exit_sense (exit_sense),
        .car_count  (car_count),
        .full       (full),
        .empty      (empty),
        .err_pulse  (err_pulse),
        .entered_stb(entered_stb),
        .exited_stb (exited_stb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input int c, input bit e,
                           input bit si, input bit so);
        chk({tag, " count"}, int'(car_count), c);
        chk({tag, " err"}, int'(err_pulse), int'(e));
        chk({tag, " entered_stb"}, int'(entered_stb), int'(si));
        chk({tag, " exited_stb"}, int'(exited_stb), int'(so));
        chk({"R6 ", tag, " full"}, int'(full), int'(c == MAX));
        chk({"R6 ", tag, " empty"}, int'(empty), int'(c == 0));
    endtask

    // Drive one event of len cycles; results due after the third rising edge (R10)
    task automatic car_event(input bit en, input bit ex, input int len, input string tag);
        bit e_err = 1'b0, e_in = 1'b0, e_out = 1'b0;
        if (en && ex) begin
            e_in = 1'b1; e_out = 1'b1;
        end else if (en) begin
            if (exp_count == MAX) e_err = 1'b1;
            else begin exp_count++; e_in = 1'b1; end
        end else if (ex) begin
            if (exp_count == 0) e_err = 1'b1;
            else begin exp_count--; e_out = 1'b1; end
        end
        entry_sense = en;
        exit_sense  = ex;
        for (int c = 1; c <= len + 3; c++) begin
            @(negedge clk);
            if (c == len) begin
                entry_sense = 1'b0;
                exit_sense  = 1'b0;
            end
            if (c == 3) chk_all({"R10 ", tag}, exp_count, e_err, e_in, e_out);
            if (c == 4) chk_all({"R9 ", tag}, exp_count, 1'b0, 1'b0, 1'b0);
        end
        chk({"R2 ", tag, " settled"}, int'(car_count), exp_count);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R7: reset state
        chk_all("R7 reset", 0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: departure from an empty park
        car_event(1'b0, 1'b1, 2, "R3 exit at zero");
        // R5: pair at zero
        car_event(1'b1, 1'b1, 3, "R5 pair at zero");

        // R2: pulse lengths 1..8 each count once (R1 increments)
        for (int l = 1; l <= 8; l++) car_event(1'b1, 1'b0, l, "R2 R1 entry len sweep");
        for (int l = 1; l <= 5; l++) car_event(1'b0, 1'b1, l, "R2 R1 exit len sweep");
        car_event(1'b1, 1'b1, 4, "R5 pair mid");

        // Fill to the limit (R1, R6)
        while (exp_count < MAX) car_event(1'b1, 1'b0, 1, "R1 fill");
        // R4: arrival when full
        car_event(1'b1, 1'b0, 2, "R4 entry at max");
        car_event(1'b1, 1'b0, 1, "R4 entry at max again");
        // R5: pair when full
        car_event(1'b1, 1'b1, 1, "R5 pair at max");
        car_event(1'b0, 1'b1, 3, "R1 exit from max");
        car_event(1'b1, 1'b0, 1, "R1 refill to max");

        // R8: clear
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        exp_count = 0;
        chk_all("R8 clear", 0, 1'b0, 1'b0, 1'b0);
        car_event(1'b1, 1'b0, 2, "R8 count after clear");
        car_event(1'b1, 1'b0, 2, "R1 second after clear");

        // R7: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        exp_count = 0;
        chk_all("R7 reset mid-run", 0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        car_event(1'b1, 1'b0, 1, "R7 count after reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule